// File: doc/BRIEF.md
# Register-File Execute Datapath

This block is the execute stage of a 32-bit processor whose arithmetic and logic work only on register contents. A bank of sixteen registers feeds an ALU through two read ports. The first operand goes straight in. The second operand, which is either a register or an immediate supplied by the decoder, always passes through a one-cycle barrel shifter. The ALU result is written back to a destination register at the next clock edge. The condition flags negative, zero, carry and overflow are updated in the same edge when the decoder asks for it.

Register 15 holds the program counter, register 14 the return address and register 13 the stack pointer. A separate address stepper adds or subtracts a fixed step from any chosen register in the same cycle as the ALU operation, without using the ALU. It is normally used to advance the program counter. The decoder drives every control field directly: register indices, opcode, shift kind and amount, immediate select, write enable, flag-update enable and the stepper controls.

Top module: `exec_datapath`

## Requirements
- R1: While reset is asserted, and after it is released, all sixteen registers read as zero and `flags` is 0000.
- R2: `result` is combinational from the current inputs. The `alu_op` codes are: 0 ADD A+B, 1 SUB A-B, 2 reverse subtract B-A, 3 AND, 4 OR, 5 XOR, 6 MOV (B), 7 compare (A-B). Here B is the shifted second operand.
- R3: `shift_type` codes are: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The amount is 0 to 31, and an amount of 0 passes the operand through unchanged.
- R4: `flags` is {N,Z,C,V} on bits 3..0. After ADD, SUB, reverse subtract or compare with flag update: N is result bit 31, Z is set for a zero result, C is the adder carry-out (for subtraction, 1 means no borrow), and V is signed overflow.
- R5: After AND, OR, XOR or MOV with flag update: N and Z follow the result, C takes the last bit the shifter moved out (or keeps its old value when the amount is 0), and V keeps its old value.
- R6: When `flag_en` is low, `flags` does not change.
- R7: The destination register takes `result` at the clock edge only when `wr_en` is high and the opcode is not compare. Reads in the same cycle return the value from before that edge.
- R8: When `b_imm_sel` is 1, the shifter input is `b_imm` instead of the register selected by `src_b_idx`.
- R9: When `inc_en` is high, register `inc_idx` becomes its old value plus 4, or minus 4 when `inc_down` is 1. This happens at the same edge as, and independently of, the ALU write.
- R10: If the ALU writes the same register the stepper targets, including register 15, the ALU value is stored and the stepped value is discarded.
- R11: `pc_out` always shows register 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_idx | input | 4 | First operand register |
| src_b_idx | input | 4 | Second operand register |
| dst_idx | input | 4 | Destination register |
| alu_op | input | 3 | Operation code (R2) |
| b_imm_sel | input | 1 | Select immediate as second operand |
| b_imm | input | 32 | Immediate second operand |
| shift_type | input | 2 | Shift kind (R3) |
| shift_amt | input | 5 | Shift amount |
| flag_en | input | 1 | Update flags at the edge |
| wr_en | input | 1 | Write destination at the edge |
| inc_en | input | 1 | Step register `inc_idx` |
| inc_down | input | 1 | Step downward |
| inc_idx | input | 4 | Register the stepper updates |
| result | output | 32 | ALU result |
| flags | output | 4 | {N,Z,C,V} |
| pc_out | output | 32 | Contents of register 15 |

## Verification
A corrupted register shows up on `result` as soon as that register is chosen as a source. It shows up even sooner on `pc_out` if the register is 15, since that value is visible one edge after the bad write. A wrong flag bit is visible on `flags` in the cycle right after the update edge. A wrong held carry also changes the next zero-amount logical operation. A write-enable or priority fault between the ALU and the stepper leaves a stale or stepped value behind. It is caught on the first read of that register, which the bench performs right after each write.

// File: rtl/exec_pkg.sv
package exec_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_RSB = 3'd2,
        OP_AND = 3'd3,
        OP_ORR = 3'd4,
        OP_EOR = 3'd5,
        OP_MOV = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/exec_regbank.sv
module exec_regbank #(
    parameter int W     = 32,
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rb_idx,
    input  logic [IDX_W-1:0] rs_idx,
    output logic [W-1:0]     ra_data,
    output logic [W-1:0]     rb_data,
    output logic [W-1:0]     rs_data,
    output logic [W-1:0]     top_data,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  logic [W-1:0]     wa_data,
    input  logic             ws_en,
    input  logic [IDX_W-1:0] ws_idx,
    input  logic [W-1:0]     ws_data
);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    // Per-register next value: ALU port has priority over stepper port
    for (genvar i = 0; i < N; i++) begin : g_next
        always_comb begin
            regs_d[i] = regs_q[i];
            if (wa_en && wa_idx == IDX_W'(i)) begin
                regs_d[i] = wa_data;
            end else if (ws_en && ws_idx == IDX_W'(i)) begin
                regs_d[i] = ws_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign ra_data  = regs_q[ra_idx];
    assign rb_data  = regs_q[rb_idx];
    assign rs_data  = regs_q[rs_idx];
    assign top_data = regs_q[N-1];

endmodule

// File: rtl/exec_shifter.sv
module exec_shifter
    import exec_pkg::*;
#(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [1:0]      kind,
    input  logic [SH_W-1:0] amt,
    input  logic            cin,
    output logic [W-1:0]    dout,
    output logic            cout
);

    shift_e          kind_e;
    logic [SH_W-1:0] back_idx;
    logic [SH_W-1:0] last_idx;

    assign kind_e   = shift_e'(kind);
    assign back_idx = SH_W'(0) - amt;   // W - amt for nonzero amounts
    assign last_idx = amt - SH_W'(1);

    always_comb begin
        dout = din;
        cout = cin;
        if (amt != '0) begin
            unique case (kind_e)
                SH_LSL: begin
                    dout = din << amt;
                    cout = din[back_idx];
                end
                SH_LSR: begin
                    dout = din >> amt;
                    cout = din[last_idx];
                end
                SH_ASR: begin
                    dout = W'($signed(din) >>> amt);
                    cout = din[last_idx];
                end
                SH_ROR: begin
                    dout = (din >> amt) | (din << back_idx);
                    cout = din[last_idx];
                end
                default: begin
                    dout = din;
                    cout = cin;
                end
            endcase
        end
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sh_carry,
    input  logic [2:0]   op,
    input  flags_t       flags_cur,
    output logic [W-1:0] res,
    output flags_t       flags_nxt,
    output logic         writes_dst
);

    alu_op_e      op_e;
    logic [W:0]   sum;
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         arith;

    assign op_e = alu_op_e'(op);

    always_comb begin
        add_x = opa;
        add_y = opb;
        sum   = '0;
        arith = 1'b1;
        res   = '0;
        unique case (op_e)
            OP_ADD: begin
                sum = {1'b0, opa} + {1'b0, opb};
                res = sum[W-1:0];
            end
            OP_SUB, OP_CMP: begin
                add_y = ~opb;
                sum   = {1'b0, opa} + {1'b0, ~opb} + (W+1)'(1);
                res   = sum[W-1:0];
            end
            OP_RSB: begin
                add_x = opb;
                add_y = ~opa;
                sum   = {1'b0, opb} + {1'b0, ~opa} + (W+1)'(1);
                res   = sum[W-1:0];
            end
            OP_AND: begin
                arith = 1'b0;
                res   = opa & opb;
            end
            OP_ORR: begin
                arith = 1'b0;
                res   = opa | opb;
            end
            OP_EOR: begin
                arith = 1'b0;
                res   = opa ^ opb;
            end
            OP_MOV: begin
                arith = 1'b0;
                res   = opb;
            end
            default: begin
                arith = 1'b0;
                res   = '0;
            end
        endcase
    end

    always_comb begin
        flags_nxt.n = res[W-1];
        flags_nxt.z = (res == '0);
        if (arith) begin
            flags_nxt.c = sum[W];
            flags_nxt.v = (add_x[W-1] == add_y[W-1]) && (res[W-1] != add_x[W-1]);
        end else begin
            flags_nxt.c = sh_carry;
            flags_nxt.v = flags_cur.v;
        end
    end

    assign writes_dst = (op_e != OP_CMP);

endmodule

// File: rtl/exec_addr_step.sv
module exec_addr_step #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] cur,
    input  logic         down,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] STEP_V = W'(STEP);

    assign nxt = down ? (cur - STEP_V) : (cur + STEP_V);

endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_N  = 16,
    parameter int STEP   = 4,
    localparam int IDX_W = $clog2(REG_N),
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [2:0]        alu_op,
    input  logic              b_imm_sel,
    input  logic [DATA_W-1:0] b_imm,
    input  logic [1:0]        shift_type,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic              flag_en,
    input  logic              wr_en,
    input  logic              inc_en,
    input  logic              inc_down,
    input  logic [IDX_W-1:0]  inc_idx,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags,
    output logic [DATA_W-1:0] pc_out
);

    logic [DATA_W-1:0] ra_data;
    logic [DATA_W-1:0] rb_data;
    logic [DATA_W-1:0] rs_data;
    logic [DATA_W-1:0] step_data;
    logic [DATA_W-1:0] sh_in;
    logic [DATA_W-1:0] sh_out;
    logic              sh_carry;
    logic              writes_dst;
    flags_t            flags_q;
    flags_t            flags_d;

    exec_regbank #(.W(DATA_W), .N(REG_N)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (src_a_idx),
        .rb_idx   (src_b_idx),
        .rs_idx   (inc_idx),
        .ra_data  (ra_data),
        .rb_data  (rb_data),
        .rs_data  (rs_data),
        .top_data (pc_out),
        .wa_en    (wr_en && writes_dst),
        .wa_idx   (dst_idx),
        .wa_data  (result),
        .ws_en    (inc_en),
        .ws_idx   (inc_idx),
        .ws_data  (step_data)
    );

    assign sh_in = b_imm_sel ? b_imm : rb_data;

    exec_shifter #(.W(DATA_W)) u_shift (
        .din  (sh_in),
        .kind (shift_type),
        .amt  (shift_amt),
        .cin  (flags_q.c),
        .dout (sh_out),
        .cout (sh_carry)
    );

    exec_alu #(.W(DATA_W)) u_alu (
        .opa        (ra_data),
        .opb        (sh_out),
        .sh_carry   (sh_carry),
        .op         (alu_op),
        .flags_cur  (flags_q),
        .res        (result),
        .flags_nxt  (flags_d),
        .writes_dst (writes_dst)
    );

    exec_addr_step #(.W(DATA_W), .STEP(STEP)) u_step (
        .cur  (rs_data),
        .down (inc_down),
        .nxt  (step_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (flag_en) begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/exec_datapath_chk.sv
module exec_datapath_chk #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 16,
    parameter int STEP   = 4,
    localparam int IDX_W = $clog2(REG_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_en,
    input logic              wr_en,
    input logic              inc_en,
    input logic              inc_down,
    input logic [IDX_W-1:0]  inc_idx,
    input logic [IDX_W-1:0]  dst_idx,
    input logic [2:0]        alu_op,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags,
    input logic [DATA_W-1:0] pc_out
);

    localparam logic [IDX_W-1:0]  PC_IDX = IDX_W'(REG_N - 1);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic alu_pc_wr;
    logic step_pc;
    logic logic_op;

    assign alu_pc_wr = wr_en && (dst_idx == PC_IDX) && (alu_op != 3'd7);
    assign step_pc   = inc_en && (inc_idx == PC_IDX);
    assign logic_op  = (alu_op >= 3'd3) && (alu_op <= 3'd6);

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(flags)); // R6

    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> flags[2] == ($past(result) == '0)); // R4

    AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> flags[3] == $past(result[DATA_W-1])); // R4

    AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && logic_op) |=> flags[0] == $past(flags[0])); // R5

    AST_PC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pc && !alu_pc_wr) |=>
        pc_out == ($past(inc_down) ? $past(pc_out) - STEP_V : $past(pc_out) + STEP_V)); // R9

    AST_PC_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        alu_pc_wr |=> pc_out == $past(result)); // R10

    AST_PC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_pc && !alu_pc_wr) |=> $stable(pc_out)); // R11

endmodule

bind exec_datapath exec_datapath_chk #(
    .DATA_W (DATA_W),
    .REG_N  (REG_N),
    .STEP   (STEP)
) u_chk (.*);

// File: tb/exec_datapath_bench.sv
module exec_datapath_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0, inc_idx = '0;
    logic [2:0]  alu_op = '0;
    logic        b_imm_sel = 1'b0;
    logic [31:0] b_imm = '0;
    logic [1:0]  shift_type = '0;
    logic [4:0]  shift_amt = '0;
    logic        flag_en = 1'b0, wr_en = 1'b0, inc_en = 1'b0, inc_down = 1'b0;
    logic [31:0] result;
    logic [3:0]  flags;
    logic [31:0] pc_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    exec_datapath u_exec_datapath (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sh;
        logic [4:0]  amt;
        logic        cin;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [3:0]  fl;   // {N,Z,C,V}
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 5'd0,  1'b0, 32'd5,        32'd3,        32'd8,        4'b0000},
        '{3'd0, 2'd0, 5'd0,  1'b0, 32'h7FFFFFFF, 32'd1,        32'h80000000, 4'b1001},
        '{3'd0, 2'd0, 5'd0,  1'b0, 32'hFFFFFFFF, 32'd1,        32'h00000000, 4'b0110},
        '{3'd1, 2'd0, 5'd0,  1'b0, 32'd5,        32'd7,        32'hFFFFFFFE, 4'b1000},
        '{3'd1, 2'd0, 5'd0,  1'b0, 32'h80000000, 32'd1,        32'h7FFFFFFF, 4'b0011},
        '{3'd2, 2'd0, 5'd0,  1'b0, 32'd2,        32'd10,       32'd8,        4'b0010},
        '{3'd3, 2'd0, 5'd4,  1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b1010},
        '{3'd4, 2'd1, 5'd1,  1'b0, 32'd0,        32'h00000081, 32'h00000040, 4'b0010},
        '{3'd5, 2'd2, 5'd4,  1'b1, 32'h0000FFFF, 32'h80000000, 32'hF800FFFF, 4'b1000},
        '{3'd6, 2'd3, 5'd1,  1'b0, 32'd0,        32'd1,        32'h80000000, 4'b1010},
        '{3'd6, 2'd0, 5'd0,  1'b1, 32'd0,        32'h12345678, 32'h12345678, 4'b0010},
        '{3'd6, 2'd0, 5'd0,  1'b0, 32'd0,        32'd0,        32'd0,        4'b0100},
        '{3'd7, 2'd0, 5'd0,  1'b0, 32'd9,        32'd9,        32'd0,        4'b0110},
        '{3'd0, 2'd0, 5'd31, 1'b1, 32'd1,        32'd3,        32'h80000001, 4'b1000},
        '{3'd6, 2'd3, 5'd8,  1'b0, 32'd0,        32'h000000AB, 32'hAB000000, 4'b1010},
        '{3'd1, 2'd0, 5'd0,  1'b0, 32'd0,        32'd0,        32'd0,        4'b0110},
        '{3'd6, 2'd1, 5'd31, 1'b1, 32'd0,        32'h80000000, 32'd1,        4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one operation shortly after a rising edge; outputs settle before return
    task automatic issue(input logic [3:0] a, input logic [3:0] b, input logic [3:0] d,
                         input logic [2:0] op, input logic isel, input logic [31:0] imm,
                         input logic [1:0] sh, input logic [4:0] amt,
                         input logic fe, input logic we);
        src_a_idx = a; src_b_idx = b; dst_idx = d; alu_op = op;
        b_imm_sel = isel; b_imm = imm; shift_type = sh; shift_amt = amt;
        flag_en = fe; wr_en = we;
        #2;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        flag_en = 1'b0; wr_en = 1'b0; inc_en = 1'b0; inc_down = 1'b0;
    endtask

    task automatic load(input logic [3:0] d, input logic [31:0] v);
        issue(4'd0, 4'd0, d, 3'd6, 1'b1, v, 2'd0, 5'd0, 1'b0, 1'b1);
        tick();
    endtask

    task automatic read_reg(input logic [3:0] r, output logic [31:0] v);
        issue(4'd0, r, 4'd0, 3'd6, 1'b0, 32'd0, 2'd0, 5'd0, 1'b0, 1'b0);
        v = result;
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 flags in reset", {28'd0, flags}, 32'd0);
        chk("R1 pc in reset", pc_out, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        read_reg(4'd7, v);
        chk("R1 r7 after reset", v, 32'd0);
        chk("R1 flags after reset", {28'd0, flags}, 32'd0);

        // Vector table: R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            load(4'd1, VECS[i].a);
            load(4'd2, VECS[i].b);
            // compare r0 against 0 or 1 presets C (V cleared)
            issue(4'd0, 4'd0, 4'd0, 3'd7, 1'b1, VECS[i].cin ? 32'd0 : 32'd1,
                  2'd0, 5'd0, 1'b1, 1'b0);
            tick();
            issue(4'd1, 4'd2, 4'd3, VECS[i].op, 1'b0, 32'd0, VECS[i].sh, VECS[i].amt,
                  1'b1, 1'b1);
            chk("R2 R3 result", result, VECS[i].res);
            tick();
            chk((VECS[i].op >= 3'd3 && VECS[i].op <= 3'd6) ? "R5 flags" : "R4 flags",
                {28'd0, flags}, {28'd0, VECS[i].fl});
        end

        // R8: immediate selected over register operand
        load(4'd2, 32'hDEAD0000);
        issue(4'd0, 4'd2, 4'd0, 3'd6, 1'b1, 32'h00000123, 2'd0, 5'd0, 1'b0, 1'b0);
        chk("R8 immediate select", result, 32'h00000123);
        tick();

        // R9 R11: program counter stepping
        inc_en = 1'b1; inc_idx = 4'd15; tick();
        chk("R9 R11 pc up 1", pc_out, 32'd4);
        inc_en = 1'b1; inc_idx = 4'd15; tick();
        chk("R9 R11 pc up 2", pc_out, 32'd8);
        inc_en = 1'b1; inc_down = 1'b1; inc_idx = 4'd15; tick();
        chk("R9 pc down", pc_out, 32'd4);

        // R9: stack pointer step concurrent with an ALU write elsewhere
        load(4'd13, 32'd100);
        inc_en = 1'b1; inc_down = 1'b1; inc_idx = 4'd13;
        issue(4'd0, 4'd0, 4'd4, 3'd6, 1'b1, 32'd7, 2'd0, 5'd0, 1'b0, 1'b1);
        tick();
        read_reg(4'd13, v);
        chk("R9 r13 stepped down", v, 32'd96);
        read_reg(4'd4, v);
        chk("R9 concurrent ALU write", v, 32'd7);

        // R10: ALU write wins over stepper
        inc_en = 1'b1; inc_idx = 4'd15;
        issue(4'd0, 4'd0, 4'd15, 3'd6, 1'b1, 32'h00001000, 2'd0, 5'd0, 1'b0, 1'b1);
        tick();
        chk("R10 pc takes ALU value", pc_out, 32'h00001000);
        load(4'd6, 32'd64);
        inc_en = 1'b1; inc_idx = 4'd6;
        issue(4'd0, 4'd0, 4'd6, 3'd6, 1'b1, 32'h20, 2'd0, 5'd0, 1'b0, 1'b1);
        tick();
        read_reg(4'd6, v);
        chk("R10 r6 takes ALU value", v, 32'h20);

        // R7: compare never writes; write enable low never writes
        load(4'd3, 32'h55);
        issue(4'd3, 4'd0, 4'd3, 3'd7, 1'b1, 32'd1, 2'd0, 5'd0, 1'b0, 1'b1);
        tick();
        read_reg(4'd3, v);
        chk("R7 compare no write", v, 32'h55);
        issue(4'd0, 4'd0, 4'd3, 3'd6, 1'b1, 32'h99, 2'd0, 5'd0, 1'b0, 1'b0);
        tick();
        read_reg(4'd3, v);
        chk("R7 wr_en low no write", v, 32'h55);

        // R7: read in the write cycle sees the old value
        load(4'd8, 32'd5);
        issue(4'd8, 4'd0, 4'd8, 3'd0, 1'b1, 32'd1, 2'd0, 5'd0, 1'b0, 1'b1);
        chk("R7 old value read", result, 32'd6);
        tick();
        read_reg(4'd8, v);
        chk("R7 written value", v, 32'd6);

        // R6: flags held when flag_en low
        load(4'd1, 32'h7FFFFFFF);
        issue(4'd1, 4'd0, 4'd0, 3'd0, 1'b1, 32'd1, 2'd0, 5'd0, 1'b1, 1'b0);
        tick();
        chk("R4 overflow set", {28'd0, flags}, 32'b1001);
        issue(4'd0, 4'd0, 4'd0, 3'd1, 1'b1, 32'd0, 2'd0, 5'd0, 1'b0, 1'b0);
        tick();
        chk("R6 flags held", {28'd0, flags}, 32'b1001);

        // R5: logical op with zero amount keeps C and V
        issue(4'd0, 4'd0, 4'd0, 3'd3, 1'b1, 32'd0, 2'd0, 5'd0, 1'b1, 1'b0);
        tick();
        chk("R5 V and C held", {28'd0, flags}, 32'b0101);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule